// File: doc/BRIEF.md
# Packet-VM Branch Condition Unit

This unit resolves the control-flow instructions of a 64-bit packet-filter virtual machine. Each cycle the issue stage may present one instruction: its 8-bit opcode, the current program counter, the two operand values read from the register file (destination and source), the 32-bit immediate and the 16-bit signed branch displacement. The unit decides whether the branch is taken and computes the next program counter. It also raises a function-call request, a program-exit request or an illegal-instruction flag.

Two compare classes share a single condition table. The wide class compares the full 64-bit operands. The narrow class compares only their low 32-bit halves. Both classes cover equality, inequality, bit-test, unsigned ordering and signed ordering. The unconditional jump and the exit are accepted only in the wide class. The result is registered and appears one cycle after the request, with a valid strobe. The caller supplies the operand values, so when an exit is reported the return value is whatever the register file holds in register 0 at that moment. Call target lookup, the stack and fetch live elsewhere.

Top module: `pvm_branch_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid`, `taken`, `call_req`, `exit_req`, `illegal` and `next_pc` are all zero.
- R2: Each cycle with `in_valid` high yields exactly one result, with `out_valid` high in the following cycle. `out_valid` is low in every cycle that does not follow a request. Back-to-back requests give back-to-back results.
- R3: The opcode is split into three fields. Bits [2:0] give the class: 5 is wide (64-bit) and 6 is narrow (32-bit). Bit 3 selects the second operand: 1 takes `src_val` and 0 takes the immediate. Bits [7:4] give the operation: 0 jump, 1 equal, 2 unsigned greater, 3 unsigned greater-or-equal, 4 bit-test, 5 not-equal, 6 signed greater, 7 signed greater-or-equal, 8 call, 9 exit, 10 unsigned less, 11 unsigned less-or-equal, 12 signed less, 13 signed less-or-equal.
- R4: The 32-bit immediate is sign-extended to the compare width before it is used.
- R5: Equal and not-equal compare the whole compare width. Bit-test is taken when the bitwise AND of the two operands is nonzero.
- R6: Codes 2, 3, 10 and 11 order the operands as unsigned numbers.
- R7: Codes 6, 7, 12 and 13 order the operands as two's-complement numbers.
- R8: In the narrow class only bits [31:0] of each operand take part, and bit 31 is the sign bit.
- R9: `next_pc` counts instruction slots. It is `pc + 1 + offset` (offset sign-extended) when `taken` is high, and `pc + 1` otherwise, modulo 2^PC_W.
- R10: The jump code in the wide class is always taken. The call code, in either class, raises `call_req` with `taken` low.
- R11: The exit code in the wide class raises `exit_req` with `taken` low.
- R12: The instruction is illegal, raising `illegal` with `taken`, `call_req` and `exit_req` low, in these cases: a class other than 5 or 6, operation code 14 or 15, or the jump or exit code in the narrow class.
- R13: At most one of `taken`, `call_req`, `exit_req` and `illegal` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Operation, operand select and class |
| pc | input | PC_W (32) | Slot index of the instruction |
| dst_val | input | DATA_W (64) | First operand |
| src_val | input | DATA_W (64) | Second operand when bit 3 is set |
| imm | input | IMM_W (32) | Immediate second operand |
| offset | input | OFF_W (16) | Signed branch displacement in slots |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | Branch taken |
| next_pc | output | PC_W (32) | Slot of the next instruction |
| call_req | output | 1 | Function call requested |
| exit_req | output | 1 | Program exit requested |
| illegal | output | 1 | Illegal instruction |

## Verification
The bench instantiates the unit with DATA_W=64, IMM_W=32 and OFF_W=16, and with PC_W narrowed to 16. The narrow counter brings wraparound of the next-slot sum within reach of a single vector near 0xFFFE. Operands at the sign boundary (bit 63, and bit 31 in the narrow class) give opposite signed and unsigned outcomes. Vectors whose high halves differ but whose low halves match separate the two classes.

// File: rtl/pvm_br_pkg.sv
package pvm_br_pkg;

  typedef enum logic [3:0] {
    OP_JUMP = 4'h0, OP_EQ  = 4'h1, OP_UGT = 4'h2, OP_UGE = 4'h3,
    OP_TEST = 4'h4, OP_NE  = 4'h5, OP_SGT = 4'h6, OP_SGE = 4'h7,
    OP_CALL = 4'h8, OP_EXIT = 4'h9, OP_ULT = 4'hA, OP_ULE = 4'hB,
    OP_SLT  = 4'hC, OP_SLE = 4'hD
  } br_code_e;

  typedef enum logic [2:0] {
    K_COND, K_JUMP, K_CALL, K_EXIT, K_BAD
  } br_kind_e;

  localparam logic [2:0] CLS_WIDE   = 3'd5;
  localparam logic [2:0] CLS_NARROW = 3'd6;

endpackage

// File: rtl/pvm_br_decode.sv
module pvm_br_decode
  import pvm_br_pkg::*;
(
  input  logic [7:0] opcode,
  output br_kind_e   kind,
  output br_code_e   code,
  output logic       narrow,
  output logic       use_reg
);

  logic is_branch_class;

  always_comb begin
    code            = br_code_e'(opcode[7:4]);
    use_reg         = opcode[3];
    narrow          = (opcode[2:0] == CLS_NARROW);
    is_branch_class = (opcode[2:0] == CLS_WIDE) || narrow;
    kind            = K_BAD;
    if (is_branch_class) begin
      case (opcode[7:4])
        4'h0:        kind = narrow ? K_BAD : K_JUMP;
        4'h8:        kind = K_CALL;
        4'h9:        kind = narrow ? K_BAD : K_EXIT;
        4'hE, 4'hF:  kind = K_BAD;
        default:     kind = K_COND;
      endcase
    end
  end

endmodule

// File: rtl/pvm_br_compare.sv
module pvm_br_compare
  import pvm_br_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  br_code_e     code,
  output logic         hit
);

  logic same, ubelow, sbelow, overlap;

  always_comb begin
    same    = (lhs == rhs);
    ubelow  = (lhs < rhs);
    sbelow  = ($signed(lhs) < $signed(rhs));
    overlap = |(lhs & rhs);
    case (code)
      OP_EQ:   hit = same;
      OP_NE:   hit = !same;
      OP_TEST: hit = overlap;
      OP_UGT:  hit = !ubelow && !same;
      OP_UGE:  hit = !ubelow;
      OP_ULT:  hit = ubelow;
      OP_ULE:  hit = ubelow || same;
      OP_SGT:  hit = !sbelow && !same;
      OP_SGE:  hit = !sbelow;
      OP_SLT:  hit = sbelow;
      OP_SLE:  hit = sbelow || same;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pvm_br_target.sv
module pvm_br_target #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] offset,
  input  logic             take,
  output logic [PC_W-1:0]  next_pc
);

  logic [PC_W-1:0] off_ext;
  logic [PC_W-1:0] step;

  always_comb begin
    off_ext              = {PC_W{offset[OFF_W-1]}};
    off_ext[OFF_W-1:0]   = offset;
    step                 = take ? off_ext : '0;
    next_pc              = pc + PC_W'(1) + step;
  end

endmodule

// File: rtl/pvm_branch_unit.sv
module pvm_branch_unit
  import pvm_br_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int PC_W   = 32,
  parameter int OFF_W  = 16,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic [PC_W-1:0]   pc,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [IMM_W-1:0]  imm,
  input  logic [OFF_W-1:0]  offset,
  output logic              out_valid,
  output logic              taken,
  output logic [PC_W-1:0]   next_pc,
  output logic              call_req,
  output logic              exit_req,
  output logic              illegal
);

  localparam int HALF_W = DATA_W / 2;

  br_kind_e          kind;
  br_code_e          code;
  logic              narrow, use_reg;
  logic [DATA_W-1:0] imm_ext, rhs_full;
  logic              hit_full, hit_half, hit, take_c;
  logic [PC_W-1:0]   next_pc_c;

  pvm_br_decode u_decode (
    .opcode (opcode),
    .kind   (kind),
    .code   (code),
    .narrow (narrow),
    .use_reg(use_reg)
  );

  always_comb begin
    imm_ext            = {DATA_W{imm[IMM_W-1]}};
    imm_ext[IMM_W-1:0] = imm;
    rhs_full           = use_reg ? src_val : imm_ext;
  end

  pvm_br_compare #(.W(DATA_W)) u_cmp_wide (
    .lhs (dst_val),
    .rhs (rhs_full),
    .code(code),
    .hit (hit_full)
  );

  pvm_br_compare #(.W(HALF_W)) u_cmp_narrow (
    .lhs (dst_val[HALF_W-1:0]),
    .rhs (rhs_full[HALF_W-1:0]),
    .code(code),
    .hit (hit_half)
  );

  assign hit    = narrow ? hit_half : hit_full;
  assign take_c = (kind == K_JUMP) || ((kind == K_COND) && hit);

  pvm_br_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_target (
    .pc     (pc),
    .offset (offset),
    .take   (take_c),
    .next_pc(next_pc_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      next_pc   <= '0;
      call_req  <= 1'b0;
      exit_req  <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken    <= take_c;
        next_pc  <= next_pc_c;
        call_req <= (kind == K_CALL);
        exit_req <= (kind == K_EXIT);
        illegal  <= (kind == K_BAD);
      end
    end
  end

  assert_one_flag_R13: assert property (@(posedge clk) disable iff (rst)
    $onehot0({taken, call_req, exit_req, illegal}));

  assert_fallthrough_pc_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !taken) |-> (next_pc == $past(pc) + PC_W'(1)));

  assert_exit_source_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && exit_req) |->
      ($past(opcode[7:4]) == 4'h9 && $past(opcode[2:0]) == CLS_WIDE));

  assert_jump_taken_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode[7:4] == 4'h0 && opcode[2:0] == CLS_WIDE) |=> taken);

  assert_narrow_illegal_R12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode[2:0] == CLS_NARROW &&
     (opcode[7:4] == 4'h0 || opcode[7:4] == 4'h9)) |=> illegal);

endmodule

// File: tb/test_pvm_branch_unit.sv
module test_pvm_branch_unit;

  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [7:0]    opcode = '0;
  logic [PW-1:0] pc = '0;
  logic [63:0]   dst_val = '0, src_val = '0;
  logic [31:0]   imm = '0;
  logic [15:0]   offset = '0;
  logic          out_valid, taken, call_req, exit_req, illegal;
  logic [PW-1:0] next_pc;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic          tk;
    logic [PW-1:0] npc;
    logic          cl, ex, il;
    string         tag;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;

  pvm_branch_unit #(.DATA_W(64), .PC_W(PW), .OFF_W(16), .IMM_W(32)) i_pvm_branch_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .pc(pc),
    .dst_val(dst_val), .src_val(src_val), .imm(imm), .offset(offset),
    .out_valid(out_valid), .taken(taken), .next_pc(next_pc),
    .call_req(call_req), .exit_req(exit_req), .illegal(illegal)
  );

  function automatic exp_t model(input logic [7:0] op, input logic [PW-1:0] p,
                                 input logic [63:0] d, input logic [63:0] s,
                                 input logic [31:0] im, input logic [15:0] off,
                                 input string tag);
    exp_t e;
    logic [63:0] b, ua, ub, sa, sbv;
    logic [3:0]  c;
    logic        nar, legal, cond;
    c     = op[7:4];
    nar   = (op[2:0] == 3'd6);
    b     = op[3] ? s : {{32{im[31]}}, im};
    if (nar) begin
      ua = {32'h0, d[31:0]};          ub  = {32'h0, b[31:0]};
      sa = {{32{d[31]}}, d[31:0]};    sbv = {{32{b[31]}}, b[31:0]};
    end else begin
      ua = d; ub = b; sa = d; sbv = b;
    end
    legal = (op[2:0] == 3'd5 || nar) && c <= 4'hD && !(nar && (c == 4'h0 || c == 4'h9));
    case (c)
      4'h1: cond = ua == ub;
      4'h2: cond = ua > ub;
      4'h3: cond = ua >= ub;
      4'h4: cond = (ua & ub) != 0;
      4'h5: cond = ua != ub;
      4'h6: cond = $signed(sa) > $signed(sbv);
      4'h7: cond = $signed(sa) >= $signed(sbv);
      4'hA: cond = ua < ub;
      4'hB: cond = ua <= ub;
      4'hC: cond = $signed(sa) < $signed(sbv);
      4'hD: cond = $signed(sa) <= $signed(sbv);
      default: cond = 1'b0;
    endcase
    e.il  = !legal;
    e.cl  = legal && c == 4'h8;
    e.ex  = legal && c == 4'h9;
    e.tk  = legal && (c == 4'h0 || cond);
    e.npc = p + PW'(1) + (e.tk ? off : 16'h0);
    e.tag = tag;
    return e;
  endfunction

  task automatic apply(input logic [7:0] op, input logic [PW-1:0] p,
                       input logic [63:0] d, input logic [63:0] s,
                       input logic [31:0] im, input logic [15:0] off,
                       input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    opcode = op; pc = p; dst_val = d; src_val = s; imm = im; offset = off;
    sb.push_back(model(op, p, d, s, im, off, tag));
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R2: out_valid with no pending request (actual 1, expected 0)");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (taken !== e.tk || next_pc !== e.npc || call_req !== e.cl ||
            exit_req !== e.ex || illegal !== e.il) begin
          fails++;
          $display("FAIL %s: tk/npc/cl/ex/il actual %b/%h/%b/%b/%b expected %b/%h/%b/%b/%b",
                   e.tag, taken, next_pc, call_req, exit_req, illegal,
                   e.tk, e.npc, e.cl, e.ex, e.il);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: run did not end (actual hung, expected done)");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  localparam logic [63:0] MSB64 = 64'h8000_0000_0000_0000;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({out_valid, taken, call_req, exit_req, illegal} !== 5'b0 || next_pc !== '0) begin
      fails++;
      $display("FAIL R1: reset outputs actual %b%b%b%b%b/%h expected 00000/0000",
               out_valid, taken, call_req, exit_req, illegal, next_pc);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || taken !== 1'b0 || next_pc !== '0) begin
      fails++;
      $display("FAIL R1: first cycle after reset actual %b/%b/%h expected 0/0/0000",
               out_valid, taken, next_pc);
    end

    // R5 equality with register operand, forward displacement (R9)
    apply(8'h1D, 16'd100, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 0, 16'd5, "R5");
    // R4 immediate sign extension
    apply(8'h15, 16'd7, 64'hFFFF_FFFF_FFFF_FFFF, 0, 32'hFFFF_FFFF, 16'd2, "R4");
    apply(8'h55, 16'd7, 64'h0000_0000_FFFF_FFFF, 0, 32'hFFFF_FFFF, 16'd2, "R4");
    // R6 unsigned vs R7 signed at the sign boundary
    apply(8'h2D, 16'd20, MSB64, 64'd1, 0, 16'd3, "R6");
    apply(8'h6D, 16'd20, MSB64, 64'd1, 0, 16'd3, "R7");
    apply(8'h3D, 16'd20, 64'd9, 64'd9, 0, 16'd3, "R6");
    apply(8'h7D, 16'd20, -64'sd5, -64'sd5, 0, 16'd3, "R7");
    apply(8'hAD, 16'd20, 64'd1, MSB64, 0, 16'd3, "R6");
    apply(8'hBD, 16'd20, 64'd5, 64'd4, 0, 16'd3, "R6");
    apply(8'hCD, 16'd20, MSB64, 64'd1, 0, 16'd3, "R7");
    apply(8'hDD, 16'd20, -64'sd1, -64'sd1, 0, 16'd3, "R7");
    // R5 bit test
    apply(8'h4D, 16'd30, 64'hF0, 64'h10, 0, 16'd1, "R5");
    apply(8'h4D, 16'd30, 64'hF0, 64'h0F, 0, 16'd1, "R5");
    // R8 narrow class
    apply(8'h1E, 16'd40, 64'hAAAA_0000_0000_0007, 64'd7, 0, 16'd4, "R8");
    apply(8'h1D, 16'd40, 64'hAAAA_0000_0000_0007, 64'd7, 0, 16'd4, "R8");
    apply(8'h6E, 16'd40, 64'h0000_0000_8000_0000, 64'd0, 0, 16'd4, "R8");
    apply(8'h2E, 16'd40, 64'h0000_0000_8000_0000, 64'd0, 0, 16'd4, "R8");
    apply(8'hA6, 16'd40, 64'hFFFF_FFFF_0000_0001, 0, 32'd2, 16'd4, "R8");
    // R10 jump, R9 backward displacement and wraparound
    apply(8'h05, 16'd10, 0, 0, 0, 16'hFFFD, "R10");
    apply(8'h05, 16'hFFFE, 0, 0, 0, 16'd3, "R9");
    apply(8'h85, 16'd50, 0, 0, 0, 16'd9, "R10");
    apply(8'h86, 16'd50, 0, 0, 0, 16'd9, "R10");
    // R11 exit
    apply(8'h95, 16'd60, 0, 0, 0, 16'd9, "R11");
    // R12 illegal forms (R3 class and code fields)
    apply(8'h06, 16'd70, 0, 0, 0, 16'd9, "R12");
    apply(8'h96, 16'd70, 0, 0, 0, 16'd9, "R12");
    apply(8'hE5, 16'd70, 0, 0, 0, 16'd9, "R12");
    apply(8'hFD, 16'd70, 0, 0, 0, 16'd9, "R12");
    apply(8'h1C, 16'd70, 64'd1, 64'd1, 0, 16'd9, "R3");
    apply(8'h1F, 16'd70, 64'd1, 64'd1, 0, 16'd9, "R3");

    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || sb.size() != 0) begin
      fails++;
      $display("FAIL R2: idle out_valid/pending actual %b/%0d expected 0/0",
               out_valid, sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule